// File: doc/BRIEF.md
# Sync-Triggered Ramp Delay Decrementer

This block holds the start value for a ramp delay and counts it down. Software writes a starting value into a shadow register whenever it likes. When an external PWM synchronisation input goes from low to high, the block copies the shadow value into an active counter. The active counter then steps down by one on every cycle where the clock enable is high. It stops at zero and stays there until the next rising sync edge.

Both the active count and the shadow value can be read back. A one-bit flag shows when the active count is zero. The flag lets a downstream ramp generator know when its start delay has run out.

The sync input passes through a register stage in the block's own clock domain and then through an edge detector. Because of this, a sync level held high loads the counter only once. A load that falls in the same cycle as a decrement wins over the decrement.

Top module: `ramp_delay_dec`

## Requirements
- R1: A write on `shadow_we` puts `shadow_wdata` into the shadow register. The new value shows on `shadow_val` after the next rising clock edge.
- R2: A shadow write never changes `active_val` in the cycle it happens. A count in progress keeps going from the value it had.
- R3: A rising edge on `pwm_sync` loads the shadow value into the active counter. The input is sampled once and then edge-detected, so `active_val` takes the shadow value two clock edges after `pwm_sync` is first seen high. No other event loads the counter.
- R4: If `pwm_sync` stays high over many cycles, the counter is loaded only once. The count keeps going down while the level stays high.
- R5: On each cycle where `tick_en` is 1, no load happens and `active_val` is not zero, `active_val` goes down by exactly one. When `tick_en` is 0, `active_val` does not change.
- R6: When `active_val` reaches zero it stays at zero, whatever `tick_en` does, until the next load. It never wraps around to all ones.
- R7: A load and a decrement can fall on the same cycle. In that case the load wins, and `active_val` takes the shadow value without the decrement.
- R8: A load uses the shadow value that was held before the clock edge. A shadow write on the same cycle as a load only affects later loads.
- R9: `at_zero` is 1 exactly when `active_val` is 0.
- R10: The shadow value 0 loads as 0. The value 0xFFFF loads and then needs exactly 65535 enabled cycles to reach zero.
- R11: A synchronous `rst` clears the shadow register, the active counter and the sync edge history. After reset `active_val` = 0, `shadow_val` = 0 and `at_zero` = 1. A sync that was high through reset does not count as an edge unless it goes low first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| shadow_we | input | 1 | Write strobe for the shadow register |
| shadow_wdata | input | 16 | Value written into the shadow register |
| pwm_sync | input | 1 | External PWM sync; its rising edge triggers a load |
| tick_en | input | 1 | Enable for the count-down step |
| active_val | output | 16 | Current active count |
| shadow_val | output | 16 | Current shadow register contents |
| at_zero | output | 1 | High whenever the active count is zero |

## Verification
The assertions assume three things about the inputs:
- `rst` is held high across the first clock edge.
- `pwm_sync` is a level that changes only between clock edges.
- `shadow_wdata` is valid on any cycle where `shadow_we` is high.

Under those assumptions, the assertions check the following on every cycle after reset:
- the decrement step,
- that the counter holds at zero,
- that the counter holds when idle,
- that a load takes priority,
- the shadow write.

The stimulus drives every input on the falling clock edge, so each one is stable at the sampling edge. Shadow writes are mostly small random values, so that counts reach zero and the saturation behaviour is exercised. Sync is driven as random pulses and long held levels. Directed runs with the extreme values 0 and 0xFFFF are added to the random phase.

// File: rtl/rdd_pkg.sv
package rdd_pkg;
    localparam int unsigned DEF_CNT_W       = 16;
    localparam int unsigned DEF_SYNC_STAGES = 1;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_DEC  = 2'd2
    } cnt_action_e;
endpackage

// File: rtl/rdd_sync_edge.sv
module rdd_sync_edge #(
    parameter int unsigned STAGES = rdd_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic rise_pulse
);
    localparam int unsigned PIPE_W = STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] pipe;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[PIPE_W-2:0], level_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pipe <= {PIPE_W{1'b1}};
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_pulse = st_q.pipe[STAGES-1] & ~st_q.pipe[STAGES];
endmodule

// File: rtl/rdd_shadow_reg.sv
module rdd_shadow_reg #(
    parameter int unsigned CNT_W = rdd_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] value
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } shadow_state_t;

    shadow_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.val = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.val <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.val;
endmodule

// File: rtl/rdd_down_counter.sv
module rdd_down_counter
    import rdd_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step_en,
    output logic [CNT_W-1:0] count,
    output logic             is_zero
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t  st_d, st_q;
    cnt_action_e act;

    always_comb begin
        if (load) begin
            act = ACT_LOAD;
        end else if (step_en && (st_q.cnt != ZERO)) begin
            act = ACT_DEC;
        end else begin
            act = ACT_HOLD;
        end

        st_d = st_q;
        unique case (act)
            ACT_LOAD: st_d.cnt = load_val;
            ACT_DEC:  st_d.cnt = st_q.cnt - ONE;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= ZERO;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign is_zero = (st_q.cnt == ZERO);
endmodule

// File: rtl/ramp_delay_dec.sv
module ramp_delay_dec #(
    parameter int unsigned CNT_W       = rdd_pkg::DEF_CNT_W,
    parameter int unsigned SYNC_STAGES = rdd_pkg::DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shadow_we,
    input  logic [CNT_W-1:0] shadow_wdata,
    input  logic             pwm_sync,
    input  logic             tick_en,
    output logic [CNT_W-1:0] active_val,
    output logic [CNT_W-1:0] shadow_val,
    output logic             at_zero
);
    logic             load_pulse;
    logic [CNT_W-1:0] shadow_q;

    rdd_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk        (clk),
        .rst        (rst),
        .level_in   (pwm_sync),
        .rise_pulse (load_pulse)
    );

    rdd_shadow_reg #(
        .CNT_W (CNT_W)
    ) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (shadow_we),
        .wr_data (shadow_wdata),
        .value   (shadow_q)
    );

    rdd_down_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (load_pulse),
        .load_val (shadow_q),
        .step_en  (tick_en),
        .count    (active_val),
        .is_zero  (at_zero)
    );

    assign shadow_val = shadow_q;
endmodule

// File: rtl/ramp_delay_dec_chk.sv
module ramp_delay_dec_chk #(
    parameter int unsigned CNT_W = rdd_pkg::DEF_CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             shadow_we,
    input logic [CNT_W-1:0] shadow_wdata,
    input logic             tick_en,
    input logic             load_pulse,
    input logic [CNT_W-1:0] active_val,
    input logic [CNT_W-1:0] shadow_val,
    input logic             at_zero
);
    localparam logic [CNT_W-1:0] ZERO = '0;

    // R1
    a_r1_shadow_write: assert property (@(posedge clk) disable iff (rst)
        shadow_we |=> shadow_val == $past(shadow_wdata));

    // R2, R5: with no load and no step, the count stays where it is
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_pulse && !tick_en) |=> $stable(active_val));

    // R4: a held sync level does not give two loads in a row
    a_r4_single_load: assert property (@(posedge clk) disable iff (rst)
        load_pulse |=> !load_pulse);

    // R5
    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
        (!load_pulse && tick_en && active_val != ZERO)
            |=> active_val == $past(active_val) - 1'b1);

    // R6
    a_r6_hold_zero: assert property (@(posedge clk) disable iff (rst)
        (!load_pulse && active_val == ZERO) |=> active_val == ZERO);

    // R7, R8
    a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_pulse |=> active_val == $past(shadow_val));

    // R9
    a_r9_zero_flag: assert property (@(posedge clk) disable iff (rst)
        $fell(at_zero) |-> $past(load_pulse));
endmodule

bind ramp_delay_dec ramp_delay_dec_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .shadow_we    (shadow_we),
    .shadow_wdata (shadow_wdata),
    .tick_en      (tick_en),
    .load_pulse   (load_pulse),
    .active_val   (active_val),
    .shadow_val   (shadow_val),
    .at_zero      (at_zero)
);

// File: tb/test_ramp_delay_dec.sv
`timescale 1ns/1ps
module test_ramp_delay_dec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        shadow_we = 1'b0;
    logic [15:0] shadow_wdata = '0;
    logic        pwm_sync = 1'b0;
    logic        tick_en = 1'b0;
    logic [15:0] active_val, shadow_val;
    logic        at_zero;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 0;

    always #10 clk = ~clk; // 50 MHz

    ramp_delay_dec i_ramp_delay_dec (
        .clk          (clk),
        .rst          (rst),
        .shadow_we    (shadow_we),
        .shadow_wdata (shadow_wdata),
        .pwm_sync     (pwm_sync),
        .tick_en      (tick_en),
        .active_val   (active_val),
        .shadow_val   (shadow_val),
        .at_zero      (at_zero)
    );

    // Reference model written from the requirements
    logic        m_s1, m_s2;
    logic [15:0] m_sh, m_act;

    function automatic logic [15:0] next_act(logic edge_seen, logic [15:0] sh,
                                             logic [15:0] act, logic en);
        if (edge_seen)               return sh;   // R3, R7, R8
        if (en && act != 16'd0)      return act - 16'd1; // R5
        return act;                               // R6
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_sh <= '0; m_act <= '0;
        end else begin
            m_s1  <= pwm_sync;
            m_s2  <= m_s1;
            if (shadow_we) m_sh <= shadow_wdata;
            m_act <= next_act(m_s1 & ~m_s2, m_sh, m_act, tick_en);
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        chk("R3 R5 R6 model active", active_val, m_act);
        chk("R1 model shadow", shadow_val, m_sh);
        chk("R9 model at_zero", {15'd0, at_zero}, {15'd0, m_act == 16'd0});
    endtask

    task automatic drive(input logic we, input logic [15:0] wd,
                         input logic sy, input logic en);
        shadow_we = we; shadow_wdata = wd; pwm_sync = sy; tick_en = en;
        cyc();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            n_fails++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        pwm_sync = 1'b1; // held high through reset (R11)
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset active", active_val, 16'd0);
        chk("R11 reset shadow", shadow_val, 16'd0);
        chk("R11 reset at_zero", {15'd0, at_zero}, 16'd1);

        // R11: sync high through reset is not an edge
        drive(1, 16'd9, 1, 0);
        drive(0, 0, 1, 0);
        drive(0, 0, 1, 0);
        chk("R11 no load from held sync", active_val, 16'd0);
        drive(0, 0, 0, 0);

        // R3: latency of two edges after sync first high
        drive(0, 0, 1, 0);
        chk("R3 not yet loaded", active_val, 16'd0);
        drive(0, 0, 1, 0);
        chk("R3 loaded", active_val, 16'd9);

        // R4: held level, only one load while counting
        for (int i = 0; i < 4; i++) drive(0, 0, 1, 1);
        chk("R4 single load while held", active_val, 16'd5);

        // R2: shadow write during count
        drive(1, 16'd300, 1, 1);
        chk("R2 count undisturbed", active_val, 16'd4);
        chk("R1 shadow written", shadow_val, 16'd300);

        // R6: reach zero and stay
        for (int i = 0; i < 8; i++) drive(0, 0, 0, 1);
        chk("R6 saturate", active_val, 16'd0);
        chk("R9 flag at zero", {15'd0, at_zero}, 16'd1);

        // R7 + R8: load with decrement and shadow write same cycle
        drive(0, 0, 1, 1);            // sync seen
        drive(1, 16'd77, 1, 1);       // edge cycle: write + step
        chk("R7 R8 load wins old shadow", active_val, 16'd300);
        drive(0, 0, 0, 1);
        chk("R5 step after load", active_val, 16'd299);

        // R10: zero load
        drive(1, 16'd0, 0, 0);
        drive(0, 0, 1, 0);
        drive(0, 0, 0, 0);
        chk("R10 zero loads", active_val, 16'd0);

        // R10: full-scale load and count
        drive(1, 16'hFFFF, 0, 0);
        drive(0, 0, 1, 0);
        drive(0, 0, 1, 1);
        chk("R10 full scale load", active_val, 16'hFFFF);
        for (int i = 0; i < 65534; i++) drive(0, 0, 0, 1);
        chk("R10 one left", active_val, 16'd1);
        drive(0, 0, 0, 1);
        chk("R10 reached zero", active_val, 16'd0);
        drive(0, 0, 0, 1);
        chk("R6 no wrap", active_val, 16'd0);

        // Random phase
        for (int i = 0; i < 20000; i++) begin
            logic        we;
            logic [15:0] wd;
            we = ($urandom % 8) == 0;
            case ($urandom % 10)
                0:       wd = 16'hFFFF;
                1:       wd = 16'd0;
                default: wd = 16'($urandom % 64);
            endcase
            drive(we, wd, ($urandom % 6) == 0 ? ~pwm_sync : pwm_sync,
                  ($urandom % 4) != 0);
        end

        // R11: reset mid-count
        drive(1, 16'd50, 0, 0);
        drive(0, 0, 1, 0);
        drive(0, 0, 1, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset clears active", active_val, 16'd0);
        chk("R11 reset clears shadow", shadow_val, 16'd0);

        done = 1;
        finish_run();
    end
endmodule